// File: doc/BRIEF.md
# Curve-Engine Register Front-End

This block is the bus-facing control and status layer of an elliptic-curve arithmetic engine. A 32-bit register bus with separate write and read strobes reaches a configuration word, a one-bit completion interrupt (raw, enable, masked status and a write-only clear), a constant version word, and six operand windows of eight 32-bit words each. The windows hold the scalar k, the input point (Px, Py) and the result point (Qx, Qy, Qz).

Software programs the operands and the configuration, then sets the start bit. The front-end sends a one-cycle launch pulse to the engine, along with the work mode, the curve width and the modulus choice. While the operation runs, the operand windows and the work mode are locked. When the engine returns its done pulse, the start bit drops, the verification flag is captured and the completion interrupt is raised. Read data is registered and appears in the cycle after the read strobe.

Top module: `curve_regfront`

## Requirements
- R1: After reset, the configuration word (offset 0x1C) reads 0x80000000. Raw (0x0C), status (0x10) and enable (0x14) read 0, `irq` is 0, and every operand word reads 0.
- R2: A read of an offset that maps to no register or window returns 0. Address bits 1:0 are ignored everywhere.
- R3: Writing the configuration word with bit 0 = 1 while idle sets bit 0 and drives `eng_start` high for exactly one cycle. Bit 0 then stays 1, even across configuration writes with bit 0 = 0, until `eng_done`, after which it reads 0.
- R4: Writing the configuration word with bit 1 = 1 drives `eng_rst` for one cycle and clears bit 0 with no launch pulse. Bit 1 always reads 0.
- R5: Configuration bit 2 drives `eng_wide` (0 = 192-bit, 1 = 256-bit). Bits 7:4 drive `eng_mode`. Both read back unchanged.
- R6: `eng_mod_p` equals configuration bit 3 (0 = curve order, 1 = field prime) when the work mode is 8 to 11, and is 0 for every other mode.
- R7: On `eng_done`, configuration bit 29 captures `eng_verify` and holds it until the next done.
- R8: Configuration bits 31 and 30 are plain read/write bits that reset to 1 and 0.
- R9: `eng_done` sets raw bit 0. Writing 1 to bit 0 at offset 0x18 clears it. If done and the clear arrive in the same cycle, raw stays 1. Offset 0x18 reads 0.
- R10: Status bit 0 and the `irq` output both equal raw AND enable, where enable is bit 0 at 0x14.
- R11: Windows k, Px, Py, Qx, Qy and Qz start at 0x100, 0x120, 0x140, 0x160, 0x180 and 0x1A0. Each holds 8 words that can be written and read back.
- R12: While configuration bit 0 is 1, writes to the operand windows and to configuration bits 7:4 are ignored.
- R13: The version word at 0xFC reads 0x02207180 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data is returned on the next cycle |
| addr | input | ADDR_W (9) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, held between reads |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_rst | output | 1 | One-cycle engine reset pulse |
| eng_mode | output | 4 | Selected work mode |
| eng_wide | output | 1 | Curve width select (1 = 256-bit) |
| eng_mod_p | output | 1 | Modulus select, qualified by the work mode |
| eng_done | input | 1 | Completion pulse from the engine |
| eng_verify | input | 1 | Verification flag, valid with `eng_done` |
| irq | output | 1 | Masked completion interrupt |

## Verification
Several rules are checked on every cycle:
- a launch pulse never lasts two cycles;
- a done pulse always leaves raw set on the next cycle, even under a concurrent clear;
- raw never rises without a done;
- an engine reset pulse always coincides with an idle start bit;
- the work mode stays frozen while busy;
- the modulus select only reaches the engine in modes 8 to 11.

Some behaviour only the bench scenarios can show. These are the register readback values, the version constant, zero reads of unmapped offsets, and the masking of the interrupt by enable. They also include the operand window layout, checked against a random-access model, and the dropped operand writes during a busy operation.

// File: rtl/curve_regfront_pkg.sv
package curve_regfront_pkg;

    localparam int DATA_W = 32;
    localparam int MODE_W = 4;

    // word offsets of the scalar registers
    localparam logic [31:0] OFF_RAW = 32'h0000_000C;
    localparam logic [31:0] OFF_ST  = 32'h0000_0010;
    localparam logic [31:0] OFF_ENA = 32'h0000_0014;
    localparam logic [31:0] OFF_CLR = 32'h0000_0018;
    localparam logic [31:0] OFF_CFG = 32'h0000_001C;
    localparam logic [31:0] OFF_VER = 32'h0000_00FC;

    // configuration word bit positions
    localparam int CFG_START  = 0;
    localparam int CFG_RST    = 1;
    localparam int CFG_WIDE   = 2;
    localparam int CFG_MODP   = 3;
    localparam int CFG_MODE   = 4;
    localparam int CFG_VERIFY = 29;
    localparam int CFG_REGCLK = 30;
    localparam int CFG_MEMCLK = 31;

    typedef struct packed {
        logic              start;
        logic              start_pls;
        logic              rst_pls;
        logic              wide;
        logic              mod_p;
        logic [MODE_W-1:0] mode;
        logic              verify;
        logic              reg_clk;
        logic              mem_clk;
        logic              raw;
        logic              ena;
    } ctrl_t;

endpackage

// File: rtl/curve_ctrl_regs.sv
module curve_ctrl_regs
    import curve_regfront_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              ena_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_done,
    input  logic              eng_verify,
    output logic [DATA_W-1:0] cfg_word,
    output logic              raw,
    output logic              ena,
    output logic              start,
    output logic              eng_start,
    output logic              eng_rst,
    output logic [MODE_W-1:0] eng_mode,
    output logic              eng_wide,
    output logic              eng_mod_p
);

    localparam int GAP_W = CFG_VERIFY - CFG_MODE - MODE_W;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.start_pls = 1'b0;
        ctl_d.rst_pls   = 1'b0;

        // completion ends a running operation
        if (ctl_q.start && eng_done) begin
            ctl_d.start = 1'b0;
        end

        if (cfg_we) begin
            ctl_d.wide    = wdata[CFG_WIDE];
            ctl_d.mod_p   = wdata[CFG_MODP];
            ctl_d.reg_clk = wdata[CFG_REGCLK];
            ctl_d.mem_clk = wdata[CFG_MEMCLK];
            if (!ctl_q.start) begin
                ctl_d.mode = wdata[CFG_MODE +: MODE_W];
            end
            if (wdata[CFG_RST]) begin
                ctl_d.rst_pls = 1'b1;
                ctl_d.start   = 1'b0;
            end else if (!ctl_q.start && wdata[CFG_START]) begin
                ctl_d.start     = 1'b1;
                ctl_d.start_pls = 1'b1;
            end
        end

        // a completion outranks a concurrent clear
        if (eng_done) begin
            ctl_d.raw    = 1'b1;
            ctl_d.verify = eng_verify;
        end else if (clr_we && wdata[0]) begin
            ctl_d.raw = 1'b0;
        end

        if (ena_we) begin
            ctl_d.ena = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.mem_clk <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cfg_word = {ctl_q.mem_clk, ctl_q.reg_clk, ctl_q.verify,
                       {GAP_W{1'b0}}, ctl_q.mode, ctl_q.mod_p,
                       ctl_q.wide, 1'b0, ctl_q.start};

    assign raw       = ctl_q.raw;
    assign ena       = ctl_q.ena;
    assign start     = ctl_q.start;
    assign eng_start = ctl_q.start_pls;
    assign eng_rst   = ctl_q.rst_pls;
    assign eng_mode  = ctl_q.mode;
    assign eng_wide  = ctl_q.wide;
    // modular work modes are 8..11: top bits of the mode equal 2'b10
    assign eng_mod_p = ctl_q.mod_p && (ctl_q.mode[MODE_W-1 -: 2] == 2'b10);

endmodule

// File: rtl/curve_operand_store.sv
module curve_operand_store #(
    parameter int NUM_WIN   = 6,
    parameter int WIN_WORDS = 8,
    parameter int WORD_W    = 32,
    localparam int DEPTH    = NUM_WIN * WIN_WORDS,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = (we && (int'(idx) == i)) ? wdata : mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/curve_regfront.sv
module curve_regfront
    import curve_regfront_pkg::*;
#(
    parameter int          ADDR_W     = 9,
    parameter int          NUM_WIN    = 6,
    parameter int          WIN_WORDS  = 8,
    parameter logic [31:0] WIN_BASE   = 32'h0000_0100,
    parameter logic [27:0] VERSION_ID = 28'd35680640
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              eng_start,
    output logic              eng_rst,
    output logic [MODE_W-1:0] eng_mode,
    output logic              eng_wide,
    output logic              eng_mod_p,
    input  logic              eng_done,
    input  logic              eng_verify,
    output logic              irq
);

    localparam int          BYTES_W  = DATA_W / 8;
    localparam int          DEPTH    = NUM_WIN * WIN_WORDS;
    localparam int          IDX_W    = $clog2(DEPTH);
    localparam logic [31:0] WIN_END  = WIN_BASE + 32'(DEPTH * BYTES_W);

    logic [31:0]       a_word;
    logic [31:0]       win_off;
    logic              in_win;
    logic [IDX_W-1:0]  win_idx;
    logic              cfg_we, ena_we, clr_we, op_we;
    logic [DATA_W-1:0] cfg_word, op_rdata, rd_mux;
    logic              irq_raw, irq_ena, start_q;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    // word-aligned address; byte lanes are not decoded
    assign a_word  = {{(32-ADDR_W){1'b0}}, addr[ADDR_W-1:2], 2'b00};
    assign in_win  = (a_word >= WIN_BASE) && (a_word < WIN_END);
    assign win_off = a_word - WIN_BASE;
    assign win_idx = win_off[IDX_W+1:2];

    assign cfg_we = wr_en && (a_word == OFF_CFG);
    assign ena_we = wr_en && (a_word == OFF_ENA);
    assign clr_we = wr_en && (a_word == OFF_CLR);
    assign op_we  = wr_en && in_win && !start_q;

    curve_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .ena_we     (ena_we),
        .clr_we     (clr_we),
        .wdata      (wdata),
        .eng_done   (eng_done),
        .eng_verify (eng_verify),
        .cfg_word   (cfg_word),
        .raw        (irq_raw),
        .ena        (irq_ena),
        .start      (start_q),
        .eng_start  (eng_start),
        .eng_rst    (eng_rst),
        .eng_mode   (eng_mode),
        .eng_wide   (eng_wide),
        .eng_mod_p  (eng_mod_p)
    );

    curve_operand_store #(
        .NUM_WIN   (NUM_WIN),
        .WIN_WORDS (WIN_WORDS),
        .WORD_W    (DATA_W)
    ) u_ops (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (op_we),
        .idx   (win_idx),
        .wdata (wdata),
        .rdata (op_rdata)
    );

    always_comb begin
        rd_mux = '0;
        if (in_win) begin
            rd_mux = op_rdata;
        end else begin
            case (a_word)
                OFF_RAW: rd_mux = {{(DATA_W-1){1'b0}}, irq_raw};
                OFF_ST:  rd_mux = {{(DATA_W-1){1'b0}}, irq_raw & irq_ena};
                OFF_ENA: rd_mux = {{(DATA_W-1){1'b0}}, irq_ena};
                OFF_CFG: rd_mux = cfg_word;
                OFF_VER: rd_mux = {4'b0, VERSION_ID};
                default: rd_mux = '0;
            endcase
        end
        rdata_d = rd_en ? rd_mux : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
    assign irq   = irq_raw & irq_ena;

endmodule

// File: rtl/curve_regfront_chk.sv
module curve_regfront_chk
    import curve_regfront_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              eng_start,
    input logic              eng_rst,
    input logic              eng_done,
    input logic [MODE_W-1:0] eng_mode,
    input logic              eng_mod_p,
    input logic              irq_raw,
    input logic              start_q
);

    // R3
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R9
    done_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> irq_raw);

    // R9
    raw_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raw) |-> $past(eng_done));

    // R4
    rst_clears_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst |-> !start_q);

    // R12
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> $stable(eng_mode));

    // R6
    modp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_mod_p |-> (eng_mode >= 4'd8 && eng_mode <= 4'd11));

endmodule

bind curve_regfront curve_regfront_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_start (eng_start),
    .eng_rst   (eng_rst),
    .eng_done  (eng_done),
    .eng_mode  (eng_mode),
    .eng_mod_p (eng_mod_p),
    .irq_raw   (irq_raw),
    .start_q   (start_q)
);

// File: tb/sim_curve_regfront.sv
`timescale 1ns/1ps
module sim_curve_regfront;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        eng_start, eng_rst, eng_wide, eng_mod_p, irq;
    logic [3:0]  eng_mode;
    logic        eng_done = 1'b0, eng_verify = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [31:0] mdl [48];

    always #2.5 clk = ~clk;

    curve_regfront u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .eng_start(eng_start), .eng_rst(eng_rst),
        .eng_mode(eng_mode), .eng_wide(eng_wide), .eng_mod_p(eng_mod_p),
        .eng_done(eng_done), .eng_verify(eng_verify), .irq(irq)
    );

    function automatic logic [31:0] exp_cfg(logic st, logic wide, logic mp, logic [3:0] md,
                                             logic vf, logic rc, logic mc);
        return {mc, rc, vf, 21'b0, md, mp, wide, 1'b0, st};
    endfunction

    function automatic logic exp_modp(logic mp, logic [3:0] md);
        return mp && (md >= 4'd8) && (md <= 4'd11);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic finish_op(logic v);
        @(negedge clk);
        eng_done = 1'b1; eng_verify = v;
        @(negedge clk);
        eng_done = 1'b0; eng_verify = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 48; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(9'h01C, rd); chk("R1 cfg reset", rd, 32'h8000_0000);
        bus_rd(9'h00C, rd); chk("R1 raw reset", rd, 0);
        bus_rd(9'h010, rd); chk("R1 status reset", rd, 0);
        bus_rd(9'h014, rd); chk("R1 enable reset", rd, 0);
        bus_rd(9'h1BC, rd); chk("R1 operand reset", rd, 0);
        chk("R1 irq reset", {31'b0, irq}, 0);

        // R13 version constant, write ignored
        bus_rd(9'h0FC, rd); chk("R13 version", rd, 32'h0220_7180);
        bus_wr(9'h0FC, 32'h0);
        bus_rd(9'h0FF, rd); chk("R13 version after write", rd, 32'h0220_7180);

        // R2 unmapped and clear register read zero
        bus_rd(9'h020, rd); chk("R2 unmapped 0x20", rd, 0);
        bus_rd(9'h000, rd); chk("R2 unmapped 0x00", rd, 0);
        bus_rd(9'h1C0, rd); chk("R2 past windows", rd, 0);
        bus_rd(9'h018, rd); chk("R9 clear reads zero", rd, 0);

        // R8 clock bits
        bus_wr(9'h01C, 32'h4000_0000);
        bus_rd(9'h01C, rd); chk("R8 clock bits", rd, 32'h4000_0000);
        bus_wr(9'h01C, 32'h8000_0000);

        // R5 / R6 all modes, both modulus choices
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 2; p++) begin
                logic w;
                w = logic'(m[0] ^ p[0]);
                bus_wr(9'h01C, exp_cfg(1'b0, w, p[0], 4'(m), 1'b0, 1'b0, 1'b1));
                chk("R5 eng_mode", {28'b0, eng_mode}, 32'(m));
                chk("R5 eng_wide", {31'b0, eng_wide}, {31'b0, w});
                chk("R6 eng_mod_p", {31'b0, eng_mod_p}, {31'b0, exp_modp(p[0], 4'(m))});
                bus_rd(9'h01C, rd);
                chk("R5 cfg readback", rd, exp_cfg(1'b0, w, p[0], 4'(m), 1'b0, 1'b0, 1'b1));
            end
        end

        // R11 window bases, byte lanes ignored
        for (int wi = 0; wi < 6; wi++) begin
            logic [8:0] base;
            base = 9'(9'h100 + wi * 32);
            bus_wr(base + 9'd28, 32'hA500_0000 | 32'(wi));
            mdl[wi*8+7] = 32'hA500_0000 | 32'(wi);
            bus_rd(base + 9'd31, rd);
            chk("R11 window top word", rd, mdl[wi*8+7]);
        end

        // R11 random access against model
        for (int it = 0; it < 300; it++) begin
            int idx;
            idx = int'($urandom_range(47));
            if ($urandom_range(1) == 0) begin
                logic [31:0] d;
                d = $urandom;
                bus_wr(9'(9'h100 + idx * 4), d);
                mdl[idx] = d;
            end else begin
                bus_rd(9'(9'h100 + idx * 4 + int'($urandom_range(3))), rd);
                chk("R11 operand random", rd, mdl[idx]);
            end
        end

        // R3 launch, mode 5
        bus_wr(9'h01C, exp_cfg(1'b1, 1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 1'b1));
        chk("R3 start pulse", {31'b0, eng_start}, 1);
        @(negedge clk);
        chk("R3 pulse one cycle", {31'b0, eng_start}, 0);
        bus_rd(9'h01C, rd); chk("R3 start bit set", rd, exp_cfg(1'b1, 1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 1'b1));

        // R12 locked while busy
        bus_wr(9'h100, 32'hDEAD_BEEF);
        bus_rd(9'h100, rd); chk("R12 operand write ignored", rd, mdl[0]);
        bus_wr(9'h01C, exp_cfg(1'b0, 1'b1, 1'b0, 4'd9, 1'b0, 1'b0, 1'b1));
        chk("R12 mode held", {28'b0, eng_mode}, 5);
        bus_rd(9'h01C, rd); chk("R3 start survives write of 0", rd[0], 1);

        // R7 / R9 / R10 completion
        finish_op(1'b1);
        bus_rd(9'h01C, rd); chk("R3 start cleared by done", rd[0], 0);
        chk("R7 verify captured 1", rd[29], 1);
        bus_rd(9'h00C, rd); chk("R9 raw set", rd, 1);
        chk("R10 irq masked", {31'b0, irq}, 0);
        bus_rd(9'h010, rd); chk("R10 status masked", rd, 0);
        bus_wr(9'h014, 32'h1);
        chk("R10 irq enabled", {31'b0, irq}, 1);
        bus_rd(9'h010, rd); chk("R10 status enabled", rd, 1);
        bus_wr(9'h018, 32'h1);
        bus_rd(9'h00C, rd); chk("R9 raw cleared", rd, 0);
        chk("R10 irq cleared", {31'b0, irq}, 0);

        // R9 done and clear in the same cycle
        @(negedge clk);
        eng_done = 1'b1; eng_verify = 1'b0;
        wr_en = 1'b1; addr = 9'h018; wdata = 32'h1;
        @(negedge clk);
        eng_done = 1'b0; wr_en = 1'b0;
        bus_rd(9'h00C, rd); chk("R9 set wins over clear", rd, 1);
        bus_rd(9'h01C, rd); chk("R7 verify captured 0", rd[29], 0);
        bus_wr(9'h018, 32'h1);

        // R4 engine reset while busy
        bus_wr(9'h01C, exp_cfg(1'b1, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0, 1'b1));
        chk("R3 second launch", {31'b0, eng_start}, 1);
        bus_wr(9'h01C, 32'h8000_0002);
        chk("R4 reset pulse", {31'b0, eng_rst}, 1);
        @(negedge clk);
        chk("R4 reset pulse one cycle", {31'b0, eng_rst}, 0);
        bus_rd(9'h01C, rd); chk("R4 start cleared, bit1 reads 0", rd, exp_cfg(1'b0, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0, 1'b1));

        // R4 start and reset together: no launch
        bus_wr(9'h01C, 32'h8000_0003);
        chk("R4 no launch with reset", {31'b0, eng_start}, 0);
        chk("R4 reset with start", {31'b0, eng_rst}, 1);
        bus_rd(9'h01C, rd); chk("R4 start stays clear", rd[0], 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule